// File: doc/BRIEF.md
# Key-Gated JTAG Scan Chain Controller

This block is the boundary TAP of a device whose debug TAPs stay hidden behind a 128-bit secret. After any reset, a host sees a single TAP with a 5-bit instruction register. From that TAP it can read an identification code, bypass the device, or shift a key. The key is shifted in one DR scan of 128 bits and compared against a key fixed at build time. The comparison happens in Update-DR, so a host that then passes through Run-Test/Idle sees the result at once.

After a correct key, the host may write an 8-bit chain-control register. Bit 0 of that register splices two downstream TAP segments into the serial path. The controller's own serial output then feeds the downstream segments, and the device TDO pin returns whatever comes back from them. The resulting chain, counted from TDO, is the first downstream TAP, then the second, then this controller nearest TDI. Removing the segments again takes only a TAP reset. Clearing the unlocked state takes a power-on reset.

All logic runs on TCK. Resets are synchronous and active low, so TCK must toggle while a reset is held. The serial output changes on the falling edge of TCK.

Top module: `sjt_secure_tap`

## Requirements
- R1: Entering Test-Logic-Reset loads instruction 0x02 (IDCODE) into the IR. Entry happens through five rising TCK edges with TMS high, through `trst_n` low, or through `por_n` low. An IR scan captures 5'b00001, which is shifted out LSB first.
- R2: Instruction 0x02 selects a 32-bit register that captures {4-bit version (default 0), 28'h280B0CB}, shifted out LSB first.
- R3: Any instruction other than 0x02, 0x05 and 0x0A selects a 1-bit bypass register that captures 0. Each TDI bit reaches the output one shift later.
- R4: Instruction 0x0A selects a 128-bit key register. The first bit shifted in lands in bit 0, so word 0 is sent first, LSB first. A register equal to the stored key at Update-DR sets `unlocked_o`, and it reads 1 in the Run-Test/Idle that follows.
- R5: A wrong key or a short (partial) key scan leaves the device locked. The key register captures all zeros and is cleared at every Update-DR, so nothing carries over from one scan to the next.
- R6: Instruction 0x05 selects an 8-bit chain-control register, which captures its current value. Update-DR writes it only while unlocked. Bit 0 drives `chain_en_o`.
- R7: Test-Logic-Reset, `trst_n` or `por_n` clears the chain-control register. `unlocked_o` is cleared only by `por_n`.
- R8: The controller's serial output and `tdo_oe` change on the falling edge of TCK. `tdo_oe` is 1 only while the TAP is in Shift-IR or Shift-DR. Both read 0 after reset.
- R9: When `chain_en_o` is 1, `tdo` equals `seg_tdo_i`; otherwise `tdo` equals the controller's own serial output. `seg_tdi_o` always carries the controller's own serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| trst_n | input | 1 | Test reset, synchronous, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out of the whole chain |
| tdo_oe | output | 1 | High while shifting |
| seg_tdo_i | input | 1 | Return path from the downstream segments |
| seg_tdi_o | output | 1 | Controller serial output into the downstream segments |
| chain_en_o | output | 1 | Downstream segments spliced into the path |
| unlocked_o | output | 1 | Key has matched since power-on |

## Verification
A wrong TAP state or IR value shows at the ports within one scan. The host reads a wrong capture pattern or a wrong IDCODE, or it reads the bypass bit shifted by one position. A comparator that does not match, or that matches early, changes `unlocked_o` in the Run-Test/Idle straight after the key scan. A chain-control register that ignores the lock, or that survives a reset, flips `chain_en_o` and with it the TDO source on the next falling edge. The bench therefore samples each of these points right after the scan or the reset that should produce it.

// File: rtl/sjt_pkg.sv
`timescale 1ns/1ps
// Shared types for the key-gated scan chain controller.
// Assumes the standard sixteen-state test access port sequence.
package sjt_pkg;

    typedef enum logic [3:0] {
        TS_RESET   = 4'h0,
        TS_IDLE    = 4'h1,
        TS_SEL_DR  = 4'h2,
        TS_CAP_DR  = 4'h3,
        TS_SH_DR   = 4'h4,
        TS_EX1_DR  = 4'h5,
        TS_PAU_DR  = 4'h6,
        TS_EX2_DR  = 4'h7,
        TS_UPD_DR  = 4'h8,
        TS_SEL_IR  = 4'h9,
        TS_CAP_IR  = 4'hA,
        TS_SH_IR   = 4'hB,
        TS_EX1_IR  = 4'hC,
        TS_PAU_IR  = 4'hD,
        TS_EX2_IR  = 4'hE,
        TS_UPD_IR  = 4'hF
    } tap_state_t;

    typedef enum logic [1:0] {
        DR_BYPASS = 2'd0,
        DR_IDENT  = 2'd1,
        DR_KEY    = 2'd2,
        DR_CHAIN  = 2'd3
    } dr_sel_t;

endpackage

// File: rtl/sjt_tap_fsm.sv
`timescale 1ns/1ps
// TAP state sequencer: walks the sixteen test access port states on TMS.
// Assumes synchronous active-low resets sampled on rising TCK.
module sjt_tap_fsm
    import sjt_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state_q
);

    tap_state_t state_d;

    // Next-state selection from the current state and TMS.
    always_comb begin
        state_d = state_q;
        case (state_q)
            TS_RESET:  state_d = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   state_d = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: state_d = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: state_d = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  state_d = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: state_d = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: state_d = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: state_d = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: state_d = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: state_d = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: state_d = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  state_d = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: state_d = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: state_d = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: state_d = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: state_d = tms ? TS_SEL_DR : TS_IDLE;
            default:   state_d = TS_RESET;
        endcase
    end

    // State register, forced to Test-Logic-Reset by either reset.
    always_ff @(posedge tck) begin
        if (!por_n || !trst_n) state_q <= TS_RESET;
        else                   state_q <= state_d;
    end

    // Checker: run length of TMS-high edges, saturating at five.
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (!por_n || !trst_n) ones_run <= 3'd5;
        else if (!tms)         ones_run <= 3'd0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    // R1: five TMS-high edges always end in Test-Logic-Reset.
    p_five_ones_reset_r1: assert property (@(posedge tck) disable iff (!por_n)
        (ones_run == 3'd5) |-> (state_q == TS_RESET));

    // R7: a test reset forces Test-Logic-Reset on the next edge.
    p_trst_forces_reset_r7: assert property (@(posedge tck) disable iff (!por_n)
        !trst_n |=> (state_q == TS_RESET));

endmodule

// File: rtl/sjt_ir_reg.sv
`timescale 1ns/1ps
// Instruction register: capture, shift and update of the IR.
// Assumes IR_W >= 2; the capture value puts 01 in the two low bits.
module sjt_ir_reg
    import sjt_pkg::*;
#(
    parameter int              IR_W     = 5,
    parameter logic [IR_W-1:0] RESET_OP = 5'h02
) (
    input  logic            tck,
    input  logic            por_n,
    input  logic            trst_n,
    input  tap_state_t      state_q,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so
);

    localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);

    logic [IR_W-1:0] ir_sr;

    // IR shift stage and latched instruction.
    always_ff @(posedge tck) begin
        if (!por_n || !trst_n) begin
            ir_sr <= IR_CAPTURE;
            ir_q  <= RESET_OP;
        end else begin
            case (state_q)
                TS_RESET:  ir_q  <= RESET_OP;
                TS_CAP_IR: ir_sr <= IR_CAPTURE;
                TS_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                TS_UPD_IR: ir_q  <= ir_sr;
                default:   ;
            endcase
        end
    end

    assign ir_so = ir_sr[0];

    // R1: Test-Logic-Reset leaves the identification instruction selected.
    p_reset_selects_ident_r1: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == TS_RESET) |=> (ir_q == RESET_OP));

    // R1: the instruction only changes in Update-IR or Test-Logic-Reset.
    p_ir_holds_r1: assert property (@(posedge tck) disable iff (!por_n || !trst_n)
        !(state_q inside {TS_RESET, TS_UPD_IR}) |=> $stable(ir_q));

endmodule

// File: rtl/sjt_key_unit.sv
`timescale 1ns/1ps
// Key register and comparator: collects a key in one DR scan and latches
// an unlocked flag when it equals KEY_VALUE at Update-DR.
// Assumes the first shifted bit is bit 0 of word 0.
module sjt_key_unit
    import sjt_pkg::*;
#(
    parameter int                          WORD_W    = 32,
    parameter int                          KEY_WORDS = 4,
    parameter logic [WORD_W*KEY_WORDS-1:0] KEY_VALUE = '0
) (
    input  logic       tck,
    input  logic       por_n,
    input  logic       trst_n,
    input  tap_state_t state_q,
    input  logic       sel_key,
    input  logic       tdi,
    output logic       key_so,
    output logic       unlocked_o
);

    localparam int KEY_W = WORD_W * KEY_WORDS;

    logic [KEY_W-1:0]     key_sr;
    logic [KEY_WORDS-1:0] word_hit;
    logic                 key_match;

    // Per-word equality, so the compare splits into narrow trees.
    for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
        assign word_hit[w] = (key_sr[w*WORD_W +: WORD_W] == KEY_VALUE[w*WORD_W +: WORD_W]);
    end
    assign key_match = &word_hit;

    // Key shift register: zero on capture and after every update.
    always_ff @(posedge tck) begin
        if (!por_n || !trst_n) begin
            key_sr <= '0;
        end else if (sel_key) begin
            case (state_q)
                TS_CAP_DR: key_sr <= '0;
                TS_SH_DR:  key_sr <= {tdi, key_sr[KEY_W-1:1]};
                TS_UPD_DR: key_sr <= '0;
                default:   ;
            endcase
        end
    end

    // Unlocked flag: set by a matching update, cleared only at power-on.
    always_ff @(posedge tck) begin
        if (!por_n) unlocked_o <= 1'b0;
        else if (sel_key && state_q == TS_UPD_DR && key_match) unlocked_o <= 1'b1;
    end

    assign key_so = key_sr[0];

    // R7: once set, the unlocked flag stays set until power-on reset.
    p_unlock_sticky_r7: assert property (@(posedge tck) disable iff (!por_n)
        unlocked_o |=> unlocked_o);

    // R4: the flag can only rise out of Update-DR.
    p_unlock_from_update_r4: assert property (@(posedge tck) disable iff (!por_n)
        $rose(unlocked_o) |-> ($past(state_q) == TS_UPD_DR));

    // R5: no key bits survive an update.
    p_key_cleared_r5: assert property (@(posedge tck) disable iff (!por_n)
        (sel_key && state_q == TS_UPD_DR) |=> (key_sr == '0));

endmodule

// File: rtl/sjt_chain_ctl.sv
`timescale 1ns/1ps
// Chain-control register: captures its value, accepts writes only while
// unlocked, and its bit 0 splices the downstream segments in.
// Assumes unlocked comes from the key unit in the same TCK domain.
module sjt_chain_ctl
    import sjt_pkg::*;
#(
    parameter int CTL_W = 8
) (
    input  logic       tck,
    input  logic       por_n,
    input  logic       trst_n,
    input  tap_state_t state_q,
    input  logic       sel_chain,
    input  logic       unlocked,
    input  logic       tdi,
    output logic       ctl_so,
    output logic       chain_en_o
);

    logic [CTL_W-1:0] ctl_sr;
    logic [CTL_W-1:0] ctl_q;

    // Shift stage for the control register.
    always_ff @(posedge tck) begin
        if (!por_n || !trst_n) begin
            ctl_sr <= '0;
        end else if (sel_chain) begin
            if (state_q == TS_CAP_DR)     ctl_sr <= ctl_q;
            else if (state_q == TS_SH_DR) ctl_sr <= {tdi, ctl_sr[CTL_W-1:1]};
        end
    end

    // Held control value, cleared by any TAP reset, written when unlocked.
    always_ff @(posedge tck) begin
        if (!por_n || !trst_n || state_q == TS_RESET) ctl_q <= '0;
        else if (sel_chain && unlocked && state_q == TS_UPD_DR) ctl_q <= ctl_sr;
    end

    assign ctl_so     = ctl_sr[0];
    assign chain_en_o = ctl_q[0];

    // R6: the segments can only be spliced in while unlocked.
    p_splice_needs_unlock_r6: assert property (@(posedge tck) disable iff (!por_n)
        $rose(chain_en_o) |-> unlocked);

    // R7: Test-Logic-Reset removes the segments.
    p_reset_drops_chain_r7: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == TS_RESET) |=> !chain_en_o);

endmodule

// File: rtl/sjt_secure_tap.sv
`timescale 1ns/1ps
// Key-gated boundary TAP. Decodes the IR, holds the identification and
// bypass registers, muxes the serial path and splices downstream segments.
// Assumes synchronous active-low resets with TCK running.
module sjt_secure_tap
    import sjt_pkg::*;
#(
    parameter int                          IR_W       = 5,
    parameter int                          WORD_W     = 32,
    parameter int                          KEY_WORDS  = 4,
    parameter int                          CTL_W      = 8,
    parameter logic [3:0]                  ID_VERSION = 4'h0,
    parameter logic [27:0]                 ID_PART    = 28'h280B0CB,
    parameter logic [IR_W-1:0]             OP_IDENT   = 5'h02,
    parameter logic [IR_W-1:0]             OP_CHAIN   = 5'h05,
    parameter logic [IR_W-1:0]             OP_KEY     = 5'h0A,
    parameter logic [WORD_W*KEY_WORDS-1:0] KEY_VALUE  =
        {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111}
) (
    input  logic tck,
    input  logic por_n,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    input  logic seg_tdo_i,
    output logic seg_tdi_o,
    output logic chain_en_o,
    output logic unlocked_o
);

    localparam int         ID_W     = 32;
    localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART};

    tap_state_t      state_q;
    logic [IR_W-1:0] ir_q;
    logic            ir_so;
    dr_sel_t         dr_sel;
    logic            key_so;
    logic            ctl_so;
    logic            dr_so;
    logic            core_so;
    logic            core_tdo_q;
    logic            oe_q;
    logic [ID_W-1:0] id_sr;
    logic            byp_q;
    logic            in_shift;

    sjt_tap_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (state_q)
    );

    sjt_ir_reg #(
        .IR_W     (IR_W),
        .RESET_OP (OP_IDENT)
    ) u_ir (
        .tck     (tck),
        .por_n   (por_n),
        .trst_n  (trst_n),
        .state_q (state_q),
        .tdi     (tdi),
        .ir_q    (ir_q),
        .ir_so   (ir_so)
    );

    // Instruction decode; anything unknown falls to bypass.
    always_comb begin
        if (ir_q == OP_IDENT)      dr_sel = DR_IDENT;
        else if (ir_q == OP_KEY)   dr_sel = DR_KEY;
        else if (ir_q == OP_CHAIN) dr_sel = DR_CHAIN;
        else                       dr_sel = DR_BYPASS;
    end

    sjt_key_unit #(
        .WORD_W    (WORD_W),
        .KEY_WORDS (KEY_WORDS),
        .KEY_VALUE (KEY_VALUE)
    ) u_key (
        .tck        (tck),
        .por_n      (por_n),
        .trst_n     (trst_n),
        .state_q    (state_q),
        .sel_key    (dr_sel == DR_KEY),
        .tdi        (tdi),
        .key_so     (key_so),
        .unlocked_o (unlocked_o)
    );

    sjt_chain_ctl #(
        .CTL_W (CTL_W)
    ) u_chain (
        .tck        (tck),
        .por_n      (por_n),
        .trst_n     (trst_n),
        .state_q    (state_q),
        .sel_chain  (dr_sel == DR_CHAIN),
        .unlocked   (unlocked_o),
        .tdi        (tdi),
        .ctl_so     (ctl_so),
        .chain_en_o (chain_en_o)
    );

    // Identification and bypass shift stages.
    always_ff @(posedge tck) begin
        if (!por_n || !trst_n) begin
            id_sr <= '0;
            byp_q <= 1'b0;
        end else begin
            if (dr_sel == DR_IDENT && state_q == TS_CAP_DR)     id_sr <= ID_VALUE;
            else if (dr_sel == DR_IDENT && state_q == TS_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
            if (dr_sel == DR_BYPASS && state_q == TS_CAP_DR)     byp_q <= 1'b0;
            else if (dr_sel == DR_BYPASS && state_q == TS_SH_DR) byp_q <= tdi;
        end
    end

    // Serial source for the selected data register.
    always_comb begin
        case (dr_sel)
            DR_IDENT: dr_so = id_sr[0];
            DR_KEY:   dr_so = key_so;
            DR_CHAIN: dr_so = ctl_so;
            default:  dr_so = byp_q;
        endcase
    end

    assign in_shift = (state_q == TS_SH_IR) || (state_q == TS_SH_DR);
    assign core_so  = (state_q == TS_SH_IR) ? ir_so : dr_so;

    // Falling-edge output stage for the controller's own serial data.
    always_ff @(negedge tck) begin
        if (!por_n || !trst_n) begin
            core_tdo_q <= 1'b0;
            oe_q       <= 1'b0;
        end else begin
            oe_q <= in_shift;
            if (in_shift) core_tdo_q <= core_so;
        end
    end

    assign seg_tdi_o = core_tdo_q;
    assign tdo       = chain_en_o ? seg_tdo_i : core_tdo_q;
    assign tdo_oe    = oe_q;

    // R8: the output enable is only seen high in a shift state.
    p_oe_only_shift_r8: assert property (@(posedge tck) disable iff (!por_n || !trst_n)
        tdo_oe |-> in_shift);

    // R8: leaving a shift state drops the enable by the next rising edge.
    p_oe_drops_r8: assert property (@(posedge tck) disable iff (!por_n || !trst_n)
        (state_q == TS_EX1_DR || state_q == TS_EX1_IR) |-> !tdo_oe);

endmodule

// File: tb/sjt_secure_tap_tb.sv
`timescale 1ns/1ps
module sjt_secure_tap_tb;

    logic tck = 1'b0;
    logic por_n, trst_n, tms, tdi, seg_tdo_i;
    logic tdo, tdo_oe, seg_tdi_o, chain_en_o, unlocked_o;

    int nchk = 0;
    int nerr = 0;
    logic oe_all;

    localparam logic [127:0] KEY_OK  = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    localparam logic [127:0] KEY_BAD = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111110};

    typedef struct packed {
        logic [4:0]   op;
        logic [7:0]   len;
        logic [127:0] din;
        logic [127:0] exp;
        logic [3:0]   req;
    } vec_t;

    // Locked-device vectors: IR value, DR length, data in, expected data out.
    localparam vec_t VECS [0:5] = '{
        '{op: 5'h02, len: 8'd32,  din: 128'h0,    exp: 128'h0280B0CB, req: 4'd2}, // R2 ident
        '{op: 5'h1F, len: 8'd2,   din: 128'h3,    exp: 128'h2,        req: 4'd3}, // R3 bypass
        '{op: 5'h07, len: 8'd3,   din: 128'h5,    exp: 128'h2,        req: 4'd3}, // R3 undecoded
        '{op: 5'h05, len: 8'd8,   din: 128'h01,   exp: 128'h0,        req: 4'd6}, // R6 write locked
        '{op: 5'h05, len: 8'd8,   din: 128'h00,   exp: 128'h0,        req: 4'd6}, // R6 still zero
        '{op: 5'h0A, len: 8'd128, din: KEY_BAD,   exp: 128'h0,        req: 4'd5}  // R5 bad key
    };

    sjt_secure_tap u_dut (
        .tck        (tck),
        .por_n      (por_n),
        .trst_n     (trst_n),
        .tms        (tms),
        .tdi        (tdi),
        .tdo        (tdo),
        .tdo_oe     (tdo_oe),
        .seg_tdo_i  (seg_tdo_i),
        .seg_tdi_o  (seg_tdi_o),
        .chain_en_o (chain_en_o),
        .unlocked_o (unlocked_o)
    );

    always #2.5 tck = ~tck;

    task automatic check(input logic ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // One TCK cycle: drive while low, sample outputs, then the rising edge.
    task automatic tick(input logic m, input logic d, output logic so, output logic sg,
                        output logic oe);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        #1;
        so = tdo;
        sg = seg_tdi_o;
        oe = tdo_oe;
        @(posedge tck);
    endtask

    task automatic step(input logic m);
        logic a, b, c;
        tick(m, 1'b0, a, b, c);
    endtask

    // Settle point away from the edges for port observation.
    task automatic settle();
        @(negedge tck);
        #2;
    endtask

    // Full scan from Run-Test/Idle back to Run-Test/Idle.
    task automatic scan(input logic is_ir, input int len, input logic [127:0] din,
                        output logic [127:0] dout, output logic [127:0] sgout);
        logic so, sg, oe;
        dout  = '0;
        sgout = '0;
        oe_all = 1'b1;
        step(1'b1);
        if (is_ir) step(1'b1);
        step(1'b0);
        step(1'b0);
        for (int i = 0; i < len; i++) begin
            tick((i == len - 1), din[i], so, sg, oe);
            dout[i]  = so;
            sgout[i] = sg;
            oe_all   = oe_all & oe;
        end
        step(1'b1);
        step(1'b0);
    endtask

    function automatic logic [127:0] mask_of(input int len);
        return (len >= 128) ? {128{1'b1}} : ((128'd1 << len) - 128'd1);
    endfunction

    initial begin
        repeat (100000) @(posedge tck);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [127:0] dout, sgout;
        por_n = 1'b0; trst_n = 1'b1; tms = 1'b1; tdi = 1'b0; seg_tdo_i = 1'b0;
        repeat (3) @(posedge tck);
        settle();
        // R7 R8: reset state at the ports
        check(!unlocked_o, "R7 unlocked after por", {127'd0, unlocked_o}, 0);
        check(!chain_en_o, "R7 chain after por", {127'd0, chain_en_o}, 0);
        check(!tdo_oe && !tdo, "R8 tdo/oe after por", {126'd0, tdo_oe, tdo}, 0);
        por_n = 1'b1;
        step(1'b0);

        // R1: IDCODE selected out of reset without an IR scan
        scan(1'b0, 32, 128'h0, dout, sgout);
        check(dout[31:0] == 32'h0280B0CB, "R1 ident after reset", dout, 128'h0280B0CB);
        // R1: IR capture pattern
        scan(1'b1, 5, 128'h02, dout, sgout);
        check(dout[4:0] == 5'b00001, "R1 IR capture", dout, 128'h1);
        // R8: enable high during shift, low back in idle
        check(oe_all, "R8 oe during shift", {127'd0, oe_all}, 1);
        settle();
        check(!tdo_oe, "R8 oe in idle", {127'd0, tdo_oe}, 0);

        // Table of locked-device vectors (R2 R3 R5 R6)
        for (int v = 0; v < 6; v++) begin
            scan(1'b1, 5, {123'd0, VECS[v].op}, dout, sgout);
            scan(1'b0, int'(VECS[v].len), VECS[v].din, dout, sgout);
            nchk++;
            if ((dout & mask_of(int'(VECS[v].len))) != VECS[v].exp) begin
                nerr++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[v].req, v,
                         dout & mask_of(int'(VECS[v].len)), VECS[v].exp);
            end
        end
        settle();
        check(!unlocked_o, "R5 bad key stays locked", {127'd0, unlocked_o}, 0);
        check(!chain_en_o, "R6 locked write ignored", {127'd0, chain_en_o}, 0);

        // R5: two half scans must not combine into the key
        scan(1'b1, 5, 128'h0A, dout, sgout);
        scan(1'b0, 64, KEY_OK, dout, sgout);
        scan(1'b0, 64, KEY_OK >> 64, dout, sgout);
        settle();
        check(!unlocked_o, "R5 partial scans locked", {127'd0, unlocked_o}, 0);

        // R4: full correct key unlocks by Run-Test/Idle
        scan(1'b0, 128, KEY_OK, dout, sgout);
        check(dout == 128'h0, "R5 key capture zero", dout, 0);
        settle();
        check(unlocked_o, "R4 correct key unlocks", {127'd0, unlocked_o}, 1);

        // R6: write chain control while unlocked
        scan(1'b1, 5, 128'h05, dout, sgout);
        scan(1'b0, 8, 128'h01, dout, sgout);
        settle();
        check(chain_en_o, "R6 splice enabled", {127'd0, chain_en_o}, 1);

        // R9: tdo follows the returning segment
        seg_tdo_i = 1'b1;
        #0.5;
        check(tdo == 1'b1, "R9 tdo from segment high", {127'd0, tdo}, 1);
        seg_tdo_i = 1'b0;
        #0.5;
        check(tdo == 1'b0, "R9 tdo from segment low", {127'd0, tdo}, 0);

        // R6 R9: readback of control appears on the segment input
        scan(1'b0, 8, 128'h01, dout, sgout);
        check(sgout[7:0] == 8'h01, "R9 control readback on seg_tdi", sgout, 128'h01);

        // R7: five TMS-high edges drop the segments, unlock stays
        for (int k = 0; k < 5; k++) step(1'b1);
        step(1'b0);
        settle();
        check(!chain_en_o, "R7 TLR drops chain", {127'd0, chain_en_o}, 0);
        check(unlocked_o, "R7 TLR keeps unlock", {127'd0, unlocked_o}, 1);
        scan(1'b0, 32, 128'h0, dout, sgout);
        check(dout[31:0] == 32'h0280B0CB, "R1 ident after TLR", dout, 128'h0280B0CB);

        // R7: test reset drops the segments, unlock stays
        scan(1'b1, 5, 128'h05, dout, sgout);
        scan(1'b0, 8, 128'h01, dout, sgout);
        settle();
        check(chain_en_o, "R6 splice again", {127'd0, chain_en_o}, 1);
        trst_n = 1'b0;
        repeat (2) @(posedge tck);
        settle();
        check(!chain_en_o, "R7 trst drops chain", {127'd0, chain_en_o}, 0);
        check(unlocked_o, "R7 trst keeps unlock", {127'd0, unlocked_o}, 1);
        trst_n = 1'b1;
        step(1'b0);

        // R7: power-on reset clears the unlock
        @(negedge tck);
        por_n = 1'b0;
        repeat (2) @(posedge tck);
        settle();
        check(!unlocked_o, "R7 por clears unlock", {127'd0, unlocked_o}, 0);
        por_n = 1'b1;
        step(1'b0);

        // R6: locked again, control write has no effect
        scan(1'b1, 5, 128'h05, dout, sgout);
        scan(1'b0, 8, 128'h01, dout, sgout);
        scan(1'b0, 8, 128'h00, dout, sgout);
        check(dout[7:0] == 8'h00, "R6 locked control reads zero", dout, 0);
        settle();
        check(!chain_en_o, "R6 relocked write ignored", {127'd0, chain_en_o}, 0);

        finish_run();
    end

endmodule